// File: doc/BRIEF.md
# USB Root Port Status and Wake Logic

This block keeps the status and change bits of one root-hub port in a USB host controller. Line-event detectors that sit outside the block report events as single-cycle pulses. These events are attach, detach, resume K-state, over-current start and over-current end. The port-timing logic adds three more pulses: port enabled after reset, port suspended, and resume signalling complete. A small link state machine tracks the port through five states, and each accepted event updates a fixed set of bits. The block drives a host interrupt. While the function is out of its full-power state D0 (the `d0_i` input is low), it also drives a power-management wake request.

The link states are DETACHED, DISABLED, ENABLED, SUSPENDED and RESUMING. The transitions are:
- attach: DETACHED to DISABLED.
- detach: from any connected state to DETACHED.
- over-current: from ENABLED, SUSPENDED or RESUMING to DISABLED. In DISABLED it is taken with no change of state.
- enable: DISABLED to ENABLED.
- suspend: ENABLED to SUSPENDED.
- resume K-state: SUSPENDED to RESUMING.
- resume complete: RESUMING to ENABLED.

An event that is not listed for the current state is ignored. When several events arrive in the same cycle, detach beats over-current, and over-current beats the remaining events.

Software uses a one-bit-address write port. Address 0 is the control word: bit 0 is the interrupt enable, bit 1 the attach wake enable, bit 2 the detach wake enable, and bit 3 the over-current wake enable. Address 1 is write-one-to-clear for the four flags: bit 0 is connect change, bit 1 is over-current change, bit 2 is port-change-detect, and bit 3 is PME status.

Top module: `usb_port_wake_ctl`

## Requirements
- R1: After a synchronous reset the port is DETACHED and every output is 0.
- R2: An attach in DETACHED sets connected, connect change and port-change-detect. An attach while the port is already connected changes nothing.
- R3: A detach in any connected state clears connected, enabled, suspended and force-resume, and sets connect change and port-change-detect. Enabled is never 1 while connected is 0.
- R4: A resume K-state in SUSPENDED sets force-resume, which drives resume downstream, and sets port-change-detect. A resume-complete pulse in RESUMING clears force-resume and suspended and leaves the port enabled.
- R5: A resume K-state in DISABLED or ENABLED changes no bit and no output.
- R6: An over-current on a connected port sets over-current active and over-current change, clears enabled, and sets port-change-detect. An over-current end pulse clears over-current active. An over-current while DETACHED is ignored.
- R7: irq_o equals port-change-detect ANDed with control bit 0.
- R8: Writing address 1 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0. If a hardware set and a clear fall on the same flag in the same cycle, the flag ends up set.
- R9: While d0_i is 0, every accepted attach, detach, over-current or resume event sets PME status. pme_o rises for attach, detach or over-current only when that event's wake enable (control bit 1, 2 or 3) is 1, and it always rises for a resume K-state taken in SUSPENDED.
- R10: While d0_i is 1, neither PME status nor pme_o is set. pme_o falls at the clock edge after software clears PME status, or at the edge after d0_i becomes 1.
- R11: An enable pulse acts only in DISABLED (the port becomes enabled). A suspend pulse acts only in ENABLED (the port becomes suspended).
- R12: With simultaneous events, detach beats over-current and attach, and over-current beats enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| d0_i | input | 1 | 1 while the function is in full-power state D0 |
| ev_attach_i | input | 1 | Attach pulse |
| ev_detach_i | input | 1 | Detach pulse |
| ev_kstate_i | input | 1 | Resume K-state received pulse |
| ev_ocur_i | input | 1 | Over-current start pulse |
| ev_ocur_end_i | input | 1 | Over-current end pulse |
| ev_enable_i | input | 1 | Port enabled after reset pulse |
| ev_suspend_i | input | 1 | Port suspended pulse |
| ev_resume_end_i | input | 1 | Resume signalling complete pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | 0 control, 1 flag clear |
| wr_data_i | input | DATA_W | Write data |
| connected_o | output | 1 | Device connected |
| enabled_o | output | 1 | Port enabled |
| suspended_o | output | 1 | Port suspended |
| force_resume_o | output | 1 | Resume driven downstream |
| ocur_active_o | output | 1 | Over-current present |
| conn_chg_o | output | 1 | Connect change flag |
| ocur_chg_o | output | 1 | Over-current change flag |
| port_chg_o | output | 1 | Port-change-detect flag |
| pme_status_o | output | 1 | PME status flag |
| irq_o | output | 1 | Host interrupt |
| pme_o | output | 1 | Power-management wake request |

## Verification
The assertions assume that every event input is a single-cycle pulse synchronous to clk. They also assume that events which conflict with one another arrive either alone or in the combinations that the priority order settles. Each properties that checks an event outcome is conditioned on the higher-priority events being absent, so that an overriding event cannot break it. The bench raises each pulse for exactly one cycle, sets its inputs on the falling edge, and applies events together only in the dedicated priority scenario.

// File: rtl/usb_port_wake_pkg.sv
package usb_port_wake_pkg;

    typedef enum logic [2:0] {
        LNK_DETACHED,
        LNK_DISABLED,
        LNK_ENABLED,
        LNK_SUSPENDED,
        LNK_RESUMING
    } link_state_e;

    typedef struct packed {
        logic attach;
        logic detach;
        logic kstate;
        logic ocur;
        logic ocur_end;
        logic enable;
        logic suspend;
        logic resume_end;
    } line_ev_t;

    typedef struct packed {
        logic kresume;
        logic ocur;
        logic detach;
        logic attach;
    } taken_t;

    localparam int NFLAG    = 4;
    localparam int FLG_CSC  = 0;
    localparam int FLG_OCC  = 1;
    localparam int FLG_PCD  = 2;
    localparam int FLG_PME  = 3;

    localparam int CTL_IE     = 0;
    localparam int CTL_WK_ATT = 1;
    localparam int CTL_WK_DET = 2;
    localparam int CTL_WK_OC  = 3;

    localparam int CTL_ADDR = 0;
    localparam int STS_ADDR = 1;

endpackage

// File: rtl/usb_port_link_fsm.sv
module usb_port_link_fsm
    import usb_port_wake_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  line_ev_t ev_i,
    output taken_t   tk_o,
    output logic     connected_o,
    output logic     enabled_o,
    output logic     suspended_o,
    output logic     force_resume_o,
    output logic     ocur_active_o
);

    link_state_e state_q, state_d;
    taken_t      tk;
    logic        oca_q;

    // next state and accepted-event strobes, priority detach > ocur > rest
    always_comb begin
        state_d = state_q;
        tk      = '0;
        unique case (state_q)
            LNK_DETACHED: begin
                if (ev_i.attach) begin
                    state_d   = LNK_DISABLED;
                    tk.attach = 1'b1;
                end
            end
            LNK_DISABLED: begin
                if (ev_i.detach) begin
                    state_d   = LNK_DETACHED;
                    tk.detach = 1'b1;
                end else if (ev_i.ocur) begin
                    tk.ocur = 1'b1;
                end else if (ev_i.enable) begin
                    state_d = LNK_ENABLED;
                end
            end
            LNK_ENABLED: begin
                if (ev_i.detach) begin
                    state_d   = LNK_DETACHED;
                    tk.detach = 1'b1;
                end else if (ev_i.ocur) begin
                    state_d = LNK_DISABLED;
                    tk.ocur = 1'b1;
                end else if (ev_i.suspend) begin
                    state_d = LNK_SUSPENDED;
                end
            end
            LNK_SUSPENDED: begin
                if (ev_i.detach) begin
                    state_d   = LNK_DETACHED;
                    tk.detach = 1'b1;
                end else if (ev_i.ocur) begin
                    state_d = LNK_DISABLED;
                    tk.ocur = 1'b1;
                end else if (ev_i.kstate) begin
                    state_d    = LNK_RESUMING;
                    tk.kresume = 1'b1;
                end
            end
            LNK_RESUMING: begin
                if (ev_i.detach) begin
                    state_d   = LNK_DETACHED;
                    tk.detach = 1'b1;
                end else if (ev_i.ocur) begin
                    state_d = LNK_DISABLED;
                    tk.ocur = 1'b1;
                end else if (ev_i.resume_end) begin
                    state_d = LNK_ENABLED;
                end
            end
            default: state_d = LNK_DETACHED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LNK_DETACHED;
        else     state_q <= state_d;
    end

    // over-current active level, set by an accepted over-current
    always_ff @(posedge clk) begin
        if (rst)            oca_q <= 1'b0;
        else if (tk.ocur)   oca_q <= 1'b1;
        else if (ev_i.ocur_end) oca_q <= 1'b0;
    end

    // status decode from state
    always_comb begin
        connected_o    = 1'b1;
        enabled_o      = 1'b0;
        suspended_o    = 1'b0;
        force_resume_o = 1'b0;
        unique case (state_q)
            LNK_DETACHED:  connected_o = 1'b0;
            LNK_DISABLED:  enabled_o   = 1'b0;
            LNK_ENABLED:   enabled_o   = 1'b1;
            LNK_SUSPENDED: begin
                enabled_o   = 1'b1;
                suspended_o = 1'b1;
            end
            LNK_RESUMING: begin
                enabled_o      = 1'b1;
                suspended_o    = 1'b1;
                force_resume_o = 1'b1;
            end
            default: connected_o = 1'b0;
        endcase
    end

    assign tk_o          = tk;
    assign ocur_active_o = oca_q;

endmodule

// File: rtl/usb_port_chg_flags.sv
module usb_port_chg_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);

    logic [N-1:0] flag_q;

    // write-one-to-clear bits; a hardware set overrides a clear
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)           flag_q[i] <= 1'b0;
            else if (set_i[i]) flag_q[i] <= 1'b1;
            else if (clr_i[i]) flag_q[i] <= 1'b0;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/usb_port_wake_gate.sv
module usb_port_wake_gate
    import usb_port_wake_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              d0_i,
    input  taken_t            tk_i,
    input  logic              ctl_we_i,
    input  logic [DATA_W-1:0] ctl_d_i,
    input  logic              pme_clr_i,
    output logic              irq_en_o,
    output logic              pme_set_o,
    output logic              wake_o
);

    logic [DATA_W-1:0] ctl_q;
    logic              wake_q;
    logic              wake_hit;

    always_ff @(posedge clk) begin
        if (rst)           ctl_q <= '0;
        else if (ctl_we_i) ctl_q <= ctl_d_i;
    end

    // per-event wake gating outside D0; resume from suspend always wakes
    always_comb begin
        wake_hit = 1'b0;
        if (!d0_i) begin
            wake_hit = (tk_i.attach && ctl_q[CTL_WK_ATT])
                     | (tk_i.detach && ctl_q[CTL_WK_DET])
                     | (tk_i.ocur   && ctl_q[CTL_WK_OC])
                     | tk_i.kresume;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                    wake_q <= 1'b0;
        else if (wake_hit)          wake_q <= 1'b1;
        else if (d0_i || pme_clr_i) wake_q <= 1'b0;
    end

    assign pme_set_o = !d0_i && (|tk_i);
    assign irq_en_o  = ctl_q[CTL_IE];
    assign wake_o    = wake_q;

endmodule

// File: rtl/usb_port_wake_ctl.sv
module usb_port_wake_ctl
    import usb_port_wake_pkg::*;
#(
    parameter int DATA_W = 4,
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              d0_i,
    input  logic              ev_attach_i,
    input  logic              ev_detach_i,
    input  logic              ev_kstate_i,
    input  logic              ev_ocur_i,
    input  logic              ev_ocur_end_i,
    input  logic              ev_enable_i,
    input  logic              ev_suspend_i,
    input  logic              ev_resume_end_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              connected_o,
    output logic              enabled_o,
    output logic              suspended_o,
    output logic              force_resume_o,
    output logic              ocur_active_o,
    output logic              conn_chg_o,
    output logic              ocur_chg_o,
    output logic              port_chg_o,
    output logic              pme_status_o,
    output logic              irq_o,
    output logic              pme_o
);

    localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_ADDR);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(STS_ADDR);

    line_ev_t         ev;
    taken_t           tk;
    logic [NFLAG-1:0] flg_set, flg_clr, flg;
    logic             ctl_we, irq_en, pme_set;

    assign ev = '{attach:     ev_attach_i,
                  detach:     ev_detach_i,
                  kstate:     ev_kstate_i,
                  ocur:       ev_ocur_i,
                  ocur_end:   ev_ocur_end_i,
                  enable:     ev_enable_i,
                  suspend:    ev_suspend_i,
                  resume_end: ev_resume_end_i};

    assign ctl_we = wr_en_i && (wr_addr_i == A_CTL);

    always_comb begin
        flg_clr = '0;
        if (wr_en_i && (wr_addr_i == A_STS)) flg_clr = wr_data_i[NFLAG-1:0];
    end

    always_comb begin
        flg_set          = '0;
        flg_set[FLG_CSC] = tk.attach | tk.detach;
        flg_set[FLG_OCC] = tk.ocur;
        flg_set[FLG_PCD] = |tk;
        flg_set[FLG_PME] = pme_set;
    end

    usb_port_link_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .ev_i           (ev),
        .tk_o           (tk),
        .connected_o    (connected_o),
        .enabled_o      (enabled_o),
        .suspended_o    (suspended_o),
        .force_resume_o (force_resume_o),
        .ocur_active_o  (ocur_active_o)
    );

    usb_port_chg_flags #(.N(NFLAG)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (flg_set),
        .clr_i  (flg_clr),
        .flag_o (flg)
    );

    usb_port_wake_gate #(.DATA_W(DATA_W)) u_wake (
        .clk       (clk),
        .rst       (rst),
        .d0_i      (d0_i),
        .tk_i      (tk),
        .ctl_we_i  (ctl_we),
        .ctl_d_i   (wr_data_i),
        .pme_clr_i (flg_clr[FLG_PME]),
        .irq_en_o  (irq_en),
        .pme_set_o (pme_set),
        .wake_o    (pme_o)
    );

    assign conn_chg_o   = flg[FLG_CSC];
    assign ocur_chg_o   = flg[FLG_OCC];
    assign port_chg_o   = flg[FLG_PCD];
    assign pme_status_o = flg[FLG_PME];
    assign irq_o        = flg[FLG_PCD] & irq_en;

endmodule

// File: rtl/usb_port_wake_chk.sv
module usb_port_wake_chk (
    input logic clk,
    input logic rst,
    input logic d0_i,
    input logic ev_attach_i,
    input logic ev_detach_i,
    input logic ev_kstate_i,
    input logic ev_ocur_i,
    input logic wr_en_i,
    input logic connected_o,
    input logic enabled_o,
    input logic suspended_o,
    input logic force_resume_o,
    input logic ocur_active_o,
    input logic conn_chg_o,
    input logic ocur_chg_o,
    input logic port_chg_o,
    input logic pme_status_o,
    input logic irq_o,
    input logic pme_o
);

    assert_attach_R2: assert property (@(posedge clk) disable iff (rst)
        (ev_attach_i && !connected_o) |=> (connected_o && conn_chg_o && port_chg_o));

    assert_detach_R3: assert property (@(posedge clk) disable iff (rst)
        (ev_detach_i && connected_o) |=>
        (!connected_o && !enabled_o && !suspended_o && conn_chg_o && port_chg_o));

    assert_enable_needs_conn_R3: assert property (@(posedge clk) disable iff (rst)
        enabled_o |-> connected_o);

    assert_kresume_R4: assert property (@(posedge clk) disable iff (rst)
        (ev_kstate_i && suspended_o && !force_resume_o && !ev_detach_i && !ev_ocur_i)
        |=> (force_resume_o && port_chg_o));

    assert_fpr_in_suspend_R4: assert property (@(posedge clk) disable iff (rst)
        force_resume_o |-> suspended_o);

    assert_kstate_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (ev_kstate_i && connected_o && !suspended_o && !ev_detach_i && !ev_ocur_i
         && !ev_attach_i && !wr_en_i)
        |=> $stable({connected_o, enabled_o, suspended_o, force_resume_o,
                     conn_chg_o, ocur_chg_o, port_chg_o, pme_status_o}));

    assert_ocur_R6: assert property (@(posedge clk) disable iff (rst)
        (ev_ocur_i && connected_o && !ev_detach_i) |=>
        (ocur_active_o && ocur_chg_o && !enabled_o && port_chg_o));

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> port_chg_o);

    assert_wake_has_status_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(pme_o) |-> pme_status_o);

    assert_no_wake_in_d0_R10: assert property (@(posedge clk) disable iff (rst)
        $past(d0_i) |-> !pme_o);

endmodule

bind usb_port_wake_ctl usb_port_wake_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .d0_i           (d0_i),
    .ev_attach_i    (ev_attach_i),
    .ev_detach_i    (ev_detach_i),
    .ev_kstate_i    (ev_kstate_i),
    .ev_ocur_i      (ev_ocur_i),
    .wr_en_i        (wr_en_i),
    .connected_o    (connected_o),
    .enabled_o      (enabled_o),
    .suspended_o    (suspended_o),
    .force_resume_o (force_resume_o),
    .ocur_active_o  (ocur_active_o),
    .conn_chg_o     (conn_chg_o),
    .ocur_chg_o     (ocur_chg_o),
    .port_chg_o     (port_chg_o),
    .pme_status_o   (pme_status_o),
    .irq_o          (irq_o),
    .pme_o          (pme_o)
);

// File: tb/tb_usb_port_wake_ctl.sv
`timescale 1ns/1ps
module tb_usb_port_wake_ctl;

    // event codes for step()
    localparam logic [7:0] E_ATT  = 8'h01, E_DET = 8'h02, E_KST = 8'h04, E_OC  = 8'h08;
    localparam logic [7:0] E_OCE  = 8'h10, E_ENA = 8'h20, E_SUS = 8'h40, E_RSE = 8'h80;
    localparam logic [7:0] E_NONE = 8'h00;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic d0 = 1'b1;
    logic [7:0] ev = '0;
    logic wen = 1'b0;
    logic waddr = 1'b0;
    logic [3:0] wdata = '0;

    logic con, ena, sus, fpr, oca, csc, occ, pcd, pms, irq, pme;

    int vectors = 0;
    int errors  = 0;

    always #10 clk = ~clk;

    usb_port_wake_ctl dut (
        .clk(clk), .rst(rst), .d0_i(d0),
        .ev_attach_i(ev[0]), .ev_detach_i(ev[1]), .ev_kstate_i(ev[2]),
        .ev_ocur_i(ev[3]), .ev_ocur_end_i(ev[4]), .ev_enable_i(ev[5]),
        .ev_suspend_i(ev[6]), .ev_resume_end_i(ev[7]),
        .wr_en_i(wen), .wr_addr_i(waddr), .wr_data_i(wdata),
        .connected_o(con), .enabled_o(ena), .suspended_o(sus),
        .force_resume_o(fpr), .ocur_active_o(oca), .conn_chg_o(csc),
        .ocur_chg_o(occ), .port_chg_o(pcd), .pme_status_o(pms),
        .irq_o(irq), .pme_o(pme)
    );

    // status order: con ena sus fpr oca csc occ pcd pms irq pme
    function automatic logic [10:0] stat();
        return {con, ena, sus, fpr, oca, csc, occ, pcd, pms, irq, pme};
    endfunction

    task automatic check(input string req, input logic [10:0] exp);
        vectors++;
        if (stat() !== exp) begin
            errors++;
            $display("FAIL %s: status act=%b exp=%b", req, stat(), exp);
        end
    endtask

    // drive on falling edge, held through one rising edge, result visible after it
    task automatic step(input logic [7:0] e, input logic we, input logic a, input logic [3:0] d);
        @(negedge clk);
        ev = e; wen = we; waddr = a; wdata = d;
        @(negedge clk);
        ev = '0; wen = 1'b0; waddr = 1'b0; wdata = '0;
    endtask

    task automatic fire(input logic [7:0] e);
        step(e, 1'b0, 1'b0, 4'h0);
    endtask

    task automatic wr_ctl(input logic [3:0] d);
        step(E_NONE, 1'b1, 1'b0, d);
    endtask

    task automatic wr_clr(input logic [3:0] d);
        step(E_NONE, 1'b1, 1'b1, d);
    endtask

    task automatic t_reset;
        check("R1", 11'b000_0000_0000);
    endtask

    task automatic t_attach;
        fire(E_ATT);
        check("R2", 11'b100_0010_1000);
        wr_clr(4'b0111);
        check("R8", 11'b100_0000_0000);
        fire(E_ATT);
        check("R2", 11'b100_0000_0000);
    endtask

    task automatic t_link;
        fire(E_SUS);
        check("R11", 11'b100_0000_0000);
        fire(E_KST);
        check("R5", 11'b100_0000_0000);
        fire(E_ENA);
        check("R11", 11'b110_0000_0000);
        fire(E_KST);
        check("R5", 11'b110_0000_0000);
        fire(E_SUS);
        check("R11", 11'b111_0000_0000);
    endtask

    task automatic t_resume;
        fire(E_KST);
        check("R4", 11'b111_1000_1000);
        fire(E_RSE);
        check("R4", 11'b110_0000_1000);
        wr_clr(4'b0100);
        check("R8", 11'b110_0000_0000);
    endtask

    task automatic t_ocur_irq;
        wr_ctl(4'b0001);
        check("R7", 11'b110_0000_0000);
        fire(E_OC);
        check("R6", 11'b100_0101_1010);
        fire(E_OCE);
        check("R6", 11'b100_0001_1010);
        wr_clr(4'b0110);
        check("R7", 11'b100_0000_0000);
    endtask

    task automatic t_set_wins;
        step(E_DET, 1'b1, 1'b1, 4'b0101);
        check("R8", 11'b000_0010_1010);
        check("R3", 11'b000_0010_1010);
        wr_clr(4'b0000);
        check("R8", 11'b000_0010_1010);
        wr_clr(4'b0111);
        check("R8", 11'b000_0000_0000);
        fire(E_OC);
        check("R6", 11'b000_0000_0000);
    endtask

    task automatic t_wake;
        wr_ctl(4'b0000);
        d0 = 1'b0;
        fire(E_ATT);
        check("R9", 11'b100_0010_1100);
        wr_clr(4'b1111);
        wr_ctl(4'b0100);
        fire(E_DET);
        check("R9", 11'b000_0010_1101);
        wr_clr(4'b1000);
        check("R10", 11'b000_0010_1000);
        wr_clr(4'b1111);
        wr_ctl(4'b1000);
        fire(E_ATT);
        check("R9", 11'b100_0010_1100);
        wr_clr(4'b1111);
        fire(E_OC);
        check("R9", 11'b100_0101_1101);
        @(negedge clk);
        d0 = 1'b1;
        @(negedge clk);
        check("R10", 11'b100_0101_1100);
        fire(E_OCE);
        wr_clr(4'b1111);
        wr_ctl(4'b1110);
        fire(E_OC);
        check("R10", 11'b100_0101_1000);
        fire(E_OCE);
        wr_clr(4'b1111);
        check("R10", 11'b100_0000_0000);
    endtask

    task automatic t_resume_wake;
        wr_ctl(4'b0000);
        d0 = 1'b0;
        fire(E_ENA);
        fire(E_SUS);
        check("R11", 11'b111_0000_0000);
        fire(E_KST);
        check("R9", 11'b111_1000_1101);
        d0 = 1'b1;
        wr_clr(4'b1111);
        check("R10", 11'b111_1000_0000);
    endtask

    task automatic t_priority;
        fire(E_RSE);
        check("R4", 11'b110_0000_0000);
        fire(E_ATT | E_DET | E_OC);
        check("R12", 11'b000_0010_1000);
        fire(E_ATT);
        wr_clr(4'b1111);
        fire(E_OC | E_ENA);
        check("R12", 11'b100_0101_1000);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_attach();
        t_link();
        t_resume();
        t_ocur_irq();
        t_set_wins();
        t_wake();
        t_resume_wake();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule